// File: doc/BRIEF.md
# Five-Bit Eight-Function ALU

This block is a purely combinational arithmetic logic unit. It takes two 5-bit operands and a 3-bit function code. It returns a 5-bit result together with a carry flag and an overflow flag. There is no clock and no stored state, so the outputs settle from the present inputs alone.

Of the eight function codes, two pass one operand through unchanged and one adds the operands. Two complement a single operand, and the remaining three combine the operands bit by bit with AND, OR or XOR. Only the addition raises flags. Every other code forces both flags low.

The block is intended to sit inside a datapath that registers its outputs. Internally it is split into a ripple adder, a bitwise unit and a final selector.

Top module: `mini_alu`

## Requirements
- R1: Function code 3'b000 drives `res` equal to `opa`.
- R2: Function code 3'b001 drives `res` equal to `opb`.
- R3: Function code 3'b010 drives `res` with the low 5 bits of `opa + opb`, and `cflag` with bit 5 of that unsigned 6-bit sum.
- R4: Under code 3'b010, `vflag` is 1 exactly when `opa[4]` equals `opb[4]` and `res[4]` differs from them (two's-complement overflow).
- R5: Code 3'b011 drives `res` with the bitwise complement of `opa`, and code 3'b100 drives `res` with the bitwise complement of `opb`.
- R6: Codes 3'b101, 3'b110 and 3'b111 drive `res` with the bitwise AND, OR and XOR of `opa` and `opb` respectively.
- R7: For every code other than 3'b010, both `cflag` and `vflag` are 0.
- R8: Outputs depend only on the current inputs. A new input pattern is reflected on the outputs with no clock edge or prior history involved, and all-zero inputs give an all-zero result with both flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 5 | First operand |
| opb | input | 5 | Second operand |
| func | input | 3 | Function code |
| res | output | 5 | Result |
| cflag | output | 1 | Unsigned carry out of the addition |
| vflag | output | 1 | Signed overflow of the addition |

## Verification
Carry and overflow are the two outcomes that can appear together, and only under the addition code. Directed pairs separate the cases. Sixteen plus sixteen raises both flags at once. Fifteen plus one raises overflow alone, and thirty-one plus one raises carry alone. An exhaustive sweep of all operand pairs then checks, for every code, that each flag matches an independently computed sum and sign rule. Sweeping every pair under the non-adding codes shows that operands which would produce both flags leave them low.

// File: rtl/mini_alu_pkg.sv
// Package: shared widths and the function code map for the five-bit ALU.
// Assumes: the code map is fixed; only the data width is a parameter.
package mini_alu_pkg;

    localparam int DATA_W = 5;
    localparam int FUNC_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        FN_PASS_A = 3'b000,
        FN_PASS_B = 3'b001,
        FN_ADD    = 3'b010,
        FN_NOT_A  = 3'b011,
        FN_NOT_B  = 3'b100,
        FN_AND    = 3'b101,
        FN_OR     = 3'b110,
        FN_XOR    = 3'b111
    } func_e;

endpackage

// File: rtl/mini_alu_adder.sv
// Module: ripple-carry adder that also reports unsigned carry and signed
// overflow. Assumes W >= 2; overflow compares the carries into and out of
// the top bit.
module mini_alu_adder #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign cout = chain[W];
    assign ovf  = chain[W] ^ chain[W-1];

    // Guard the flags against the sign rule and unsigned wrap.
    always_comb begin
        AST_OVF_SIGN: assert (ovf == ((a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]))) else $error("overflow disagrees with sign rule"); // R4
        AST_CARRY_WRAP: assert (cout == (sum < a)) else $error("carry disagrees with unsigned wrap"); // R3
    end

endmodule

// File: rtl/mini_alu_logic.sv
// Module: non-arithmetic functions (pass, complement, AND, OR, XOR).
// Assumes: the add code is handled elsewhere; it yields zero here.
module mini_alu_logic
    import mini_alu_pkg::*;
#(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  func_e        fn,
    output logic [W-1:0] y
);

    // Decode every function code to a bitwise result.
    always_comb begin
        unique case (fn)
            FN_PASS_A: y = a;
            FN_PASS_B: y = b;
            FN_NOT_A:  y = ~a;
            FN_NOT_B:  y = ~b;
            FN_AND:    y = a & b;
            FN_OR:     y = a | b;
            FN_XOR:    y = a ^ b;
            default:   y = '0;
        endcase
    end

    // XOR checked through an independent OR-minus-AND form.
    always_comb begin
        if (fn == FN_XOR) begin
            AST_XOR_FORM: assert (y == ((a | b) & ~(a & b))) else $error("xor mismatch"); // R6
        end
    end

endmodule

// File: rtl/mini_alu.sv
// Module: top of the five-bit ALU; selects adder or bitwise result and
// gates the flags. Assumes: purely combinational, no clock or state.
module mini_alu
    import mini_alu_pkg::*;
(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [FUNC_W-1:0] func,
    output logic [DATA_W-1:0] res,
    output logic              cflag,
    output logic              vflag
);

    func_e             fn;
    logic [DATA_W-1:0] add_sum;
    logic              add_c;
    logic              add_v;
    logic [DATA_W-1:0] lg_y;
    logic              is_add;

    assign fn     = func_e'(func);
    assign is_add = (fn == FN_ADD);

    mini_alu_adder #(.W(DATA_W)) u_adder (
        .a    (opa),
        .b    (opb),
        .sum  (add_sum),
        .cout (add_c),
        .ovf  (add_v)
    );

    mini_alu_logic #(.W(DATA_W)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (fn),
        .y  (lg_y)
    );

    // Pick the result source and qualify the flags with the add code.
    always_comb begin
        res   = is_add ? add_sum : lg_y;
        cflag = is_add & add_c;
        vflag = is_add & add_v;
    end

    // Top-level guards relating ports to the code map.
    always_comb begin
        AST_FLAGS_QUIET: assert (is_add || (!cflag && !vflag)) else $error("flag outside add"); // R7
        if (fn == FN_NOT_A) begin
            AST_NOT_A_CPL: assert (((res & opa) == '0) && ((res | opa) == '1)) else $error("not-a mismatch"); // R5
        end
        if (fn == FN_PASS_B) begin
            AST_PASS_B: assert ((res ^ opb) == '0) else $error("pass-b mismatch"); // R2
        end
    end

endmodule

// File: tb/mini_alu_tb.sv
module mini_alu_tb;

    logic       clk;
    logic       rst_n;
    logic [4:0] opa, opb;
    logic [2:0] func;
    logic [4:0] res;
    logic       cflag, vflag;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 0;

    mini_alu u_dut (
        .opa   (opa),
        .opb   (opb),
        .func  (func),
        .res   (res),
        .cflag (cflag),
        .vflag (vflag)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Reference: {c, v, res} computed from the requirements.
    function automatic logic [6:0] ref_alu(input logic [2:0] f, input logic [4:0] a, input logic [4:0] b);
        logic [5:0] s;
        logic       v;
        s = {1'b0, a} + {1'b0, b};
        v = (a[4] == b[4]) && (s[4] != a[4]);
        case (f)
            3'b000: return {2'b00, a};
            3'b001: return {2'b00, b};
            3'b010: return {s[5], v, s[4:0]};
            3'b011: return {2'b00, ~a};
            3'b100: return {2'b00, ~b};
            3'b101: return {2'b00, a & b};
            3'b110: return {2'b00, a | b};
            default: return {2'b00, a ^ b};
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3/R4";
            3'b011, 3'b100: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_out(input string tag);
        logic [6:0] exp;
        exp = ref_alu(func, opa, opb);
        total++;
        if ({cflag, vflag, res} !== exp) begin
            bad++;
            $display("FAIL %s f=%b a=%0d b=%0d got c=%b v=%b r=%0d exp c=%b v=%b r=%0d",
                     tag, func, opa, opb, cflag, vflag, res, exp[6], exp[5], exp[4:0]);
        end
    endtask

    task automatic apply(input logic [2:0] f, input logic [4:0] a, input logic [4:0] b, input string tag);
        @(negedge clk);
        func = f; opa = a; opb = b;
        #1;
        check_out(tag);
        if (f != 3'b010) begin
            total++;
            if (cflag !== 1'b0 || vflag !== 1'b0) begin
                bad++;
                $display("FAIL R7 f=%b got c=%b v=%b exp 0 0", f, cflag, vflag);
            end
        end
    endtask

    initial begin
        int seed_dummy;
        rst_n = 1'b0;
        func = 3'b000; opa = '0; opb = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R8: all-zero inputs settle to all-zero outputs with no history.
        apply(3'b000, 5'd0, 5'd0, "R8");
        // R8: a changed input shows up without waiting for a clock edge.
        @(posedge clk);
        #1 opa = 5'd9;
        #1;
        total++;
        if (res !== 5'd9) begin
            bad++;
            $display("FAIL R8 got r=%0d exp r=9", res);
        end
        // Flag corners for the addition (R3, R4).
        apply(3'b010, 5'd15, 5'd1,  "R4 overflow only");
        apply(3'b010, 5'd31, 5'd1,  "R3 carry only");
        apply(3'b010, 5'd16, 5'd16, "R3/R4 both flags");
        apply(3'b010, 5'd0,  5'd0,  "R3 zero sum");
        // R7: operands that would set both flags, under non-add codes.
        for (int f = 0; f < 8; f++)
            if (f != 2) apply(3'(f), 5'd16, 5'd16, "R7 both-flag operands");
        // Exhaustive sweep of every code and operand pair.
        for (int f = 0; f < 8; f++)
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 32; b++)
                    apply(3'(f), 5'(a), 5'(b), tag_of(3'(f)));
        // Random mix with a fixed seed.
        seed_dummy = $urandom(32'd144);
        for (int k = 0; k < 300; k++) begin
            logic [2:0] rf;
            rf = 3'($urandom);
            apply(rf, 5'($urandom), 5'($urandom), tag_of(rf));
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule